// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage parallel-in, serial-out register. On each active clock edge it does one of two things: it captures a byte from its parallel inputs, or it shifts its contents one stage toward the serial output, with new serial data entering the first stage. The active edge comes from two slow inputs, an external shift clock and a clock-inhibit line, which are joined by OR. This means either input can act as the clock while the other, held low, acts as the enable. A free-running external clock can therefore be stopped and restarted by raising and lowering the inhibit.

The whole register runs on a fast free-running system clock. The external clock and the inhibit are sampled as plain inputs through a two-flop synchronizer, and a register update happens when their synchronized OR changes from 0 to 1. The select, serial and parallel data inputs are sampled in the cycle of the update. They must be held steady for at least four system cycles after the external edge.

An active-low clear overrides everything and empties the register at once. The block raises a sticky misuse flag when the inhibit rises while the clock is low, because that ordering creates an unintended edge. The flag stays set until the next clear. Only the last stage is a functional output. A debug copy of all stages is also provided.

Top module: `gated_piso`

## Requirements
- R1: With `sel_shift` high, each active edge puts `ser_in` into stage 1 (debug bit 0) and moves stage i to stage i+1.
- R2: With `sel_shift` low, an active edge loads `par_in`, with bit 0 into stage 1 and bit 7 into stage 8. Before that edge, changing `par_in` or `sel_shift` leaves the stages unchanged.
- R3: During a parallel load, `ser_in` has no effect on the loaded value.
- R4: An active edge is a 0-to-1 change of (`ext_clk` OR `clk_inh`). While `clk_inh` is held high, pulses on `ext_clk` change nothing. The stages reflect an edge within four system cycles of the input change.
- R5: With `ext_clk` held low, a rising `clk_inh` is an active edge. With `ext_clk` high, raising and then lowering `clk_inh` causes no update, and the next `ext_clk` rise updates again.
- R6: While `clr_n` is low, all stages are zero at once, whatever the clock inputs do, and `misuse_err` is 0.
- R7: Without an active edge, every stage keeps its value.
- R8: `misuse_err` sets when `clk_inh` rises while the synchronized `ext_clk` is low. It does not set when `clk_inh` rises with `ext_clk` high. Once set, only `clr_n` clears it.
- R9: `ser_out` is stage 8 (debug bit 7). After a load followed by shifts, `par_in` appears at `ser_out` from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running system clock |
| clr_n | input | 1 | Asynchronous active-low clear; its release is synchronized |
| sel_shift | input | 1 | 1 = shift, 0 = parallel load |
| ser_in | input | 1 | Serial data into stage 1 |
| par_in | input | 8 | Parallel data; bit 0 goes to stage 1 |
| ext_clk | input | 1 | External shift clock, sampled |
| clk_inh | input | 1 | Clock inhibit, sampled; ORed with `ext_clk` |
| ser_out | output | 1 | Last stage |
| stages_dbg | output | 8 | Debug copy of all stages; bit i is stage i+1 |
| misuse_err | output | 1 | Sticky flag for an inhibit rise while the clock is low |

## Verification
The bench targets five cases:
- **Inhibit used as the clock with `ext_clk` low.** A design that ANDs the inputs, or uses only `ext_clk`, would miss this update.
- **Stop and restart with the inhibit while the clock is high.** A design that detects edges on each input separately would update twice here, or flag falsely.
- **Unread bit order after a load.** A reversed order would emit bit 0 first.
- **Data changed before the edge.** An immediate, non-synchronous load would show the new byte early.
- **Clear asserted while the clock toggles.** A clear that waited for the system clock, or did not reset the flag, would leave stale stages or a set flag.

Random mixes of all five inputs are then compared step by step against a bench model. The model tracks the OR edges and the misuse rule.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } gpr_mode_e;
endpackage

// File: rtl/gpr_rst_sync.sv
module gpr_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[DEPTH-1];
endmodule

// File: rtl/gpr_sync.sv
module gpr_sync #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = pipe_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= '0;
      else        pipe_q[g] <= stage_d;
    end
  end

  assign q = pipe_q[DEPTH-1];
endmodule

// File: rtl/gpr_gate_edge.sv
module gpr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s,
  input  logic inh_s,
  output logic upd_o,
  output logic misuse_o
);
  logic clk_p_q, inh_p_q, err_q;
  logic clk_p_d, inh_p_d, err_d;
  logic gate_now, gate_prev, inh_rise;

  always_comb begin
    gate_now  = clk_s | inh_s;
    gate_prev = clk_p_q | inh_p_q;
    inh_rise  = inh_s & ~inh_p_q;
    upd_o     = gate_now & ~gate_prev;
    clk_p_d   = clk_s;
    inh_p_d   = inh_s;
    err_d     = err_q | (inh_rise & ~clk_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_p_q <= 1'b0;
      inh_p_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      clk_p_q <= clk_p_d;
      inh_p_q <= inh_p_d;
      err_q   <= err_d;
    end
  end

  assign misuse_o = err_q;
endmodule

// File: rtl/gpr_stages.sv
module gpr_stages
  import gpr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  gpr_mode_e        mode,
  input  logic             ser,
  input  logic [WIDTH-1:0] par,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (upd) begin
      case (mode)
        MODE_SHIFT: q_d = {q_q[WIDTH-2:0], ser};
        default:    q_d = par;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/gated_piso.sv
module gated_piso
  import gpr_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2,
  parameter int RST_DEPTH  = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sel_shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ext_clk,
  input  logic             clk_inh,
  output logic             ser_out,
  output logic [WIDTH-1:0] stages_dbg,
  output logic             misuse_err
);
  localparam int LAST = WIDTH - 1;

  logic       rst_sync_n;
  logic [1:0] raw_ctl, sync_ctl;
  logic       upd;
  logic [WIDTH-1:0] q;
  gpr_mode_e  mode;

  assign raw_ctl = {clk_inh, ext_clk};
  assign mode    = sel_shift ? MODE_SHIFT : MODE_LOAD;

  gpr_rst_sync #(.DEPTH(RST_DEPTH)) i_rst (
    .clk(clk), .arst_n(clr_n), .rst_n_o(rst_sync_n)
  );

  gpr_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) i_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(raw_ctl), .q(sync_ctl)
  );

  gpr_gate_edge i_edge (
    .clk(clk), .rst_n(rst_sync_n), .clk_s(sync_ctl[0]), .inh_s(sync_ctl[1]),
    .upd_o(upd), .misuse_o(misuse_err)
  );

  gpr_stages #(.WIDTH(WIDTH)) i_stages (
    .clk(clk), .rst_n(rst_sync_n), .upd(upd), .mode(mode),
    .ser(ser_in), .par(par_in), .q(q)
  );

  assign ser_out    = q[LAST];
  assign stages_dbg = q;
endmodule

// File: rtl/gated_piso_chk.sv
module gated_piso_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd,
  input logic             sel_shift,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stages,
  input logic             ser_out,
  input logic             misuse_err
);
  p_clear_zero_r6: assert property (@(posedge clk)
    !rst_n |-> (stages == '0 && !misuse_err));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(stages));

  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && sel_shift) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !sel_shift) |=> stages == $past(par_in));

  p_out_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && sel_shift) |=> ser_out == $past(stages[WIDTH-2]));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misuse_err |=> misuse_err);
endmodule

bind gated_piso gated_piso_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .upd(upd), .sel_shift(sel_shift),
  .ser_in(ser_in), .par_in(par_in), .stages(stages_dbg),
  .ser_out(ser_out), .misuse_err(misuse_err)
);

// File: tb/test_gated_piso.sv
module test_gated_piso;
  logic       clk = 1'b0;
  logic       clr_n, sel_shift, ser_in, ext_clk, clk_inh;
  logic [7:0] par_in;
  logic       ser_out, misuse_err;
  logic [7:0] stages_dbg;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic [7:0] exp_q;
  logic       exp_err;
  logic       ck_l, ih_l;

  always #10 clk = ~clk;

  gated_piso i_gated_piso (
    .clk(clk), .clr_n(clr_n), .sel_shift(sel_shift), .ser_in(ser_in),
    .par_in(par_in), .ext_clk(ext_clk), .clk_inh(clk_inh),
    .ser_out(ser_out), .stages_dbg(stages_dbg), .misuse_err(misuse_err)
  );

  function automatic logic [7:0] f_next(logic [7:0] q, logic sh, logic s, logic [7:0] p);
    return sh ? {q[6:0], s} : p;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " stages"}, stages_dbg, exp_q);
    chk({req, " ser_out"}, {7'd0, ser_out}, {7'd0, exp_q[7]});
    chk({req, " misuse_err"}, {7'd0, misuse_err}, {7'd0, exp_err});
  endtask

  task automatic step(input logic nck, input logic nih, input logic nsel,
                      input logic nser, input logic [7:0] npar, input string req);
    @(negedge clk);
    if (!(ck_l | ih_l) && (nck | nih)) exp_q = f_next(exp_q, nsel, nser, npar);
    if (nih && !ih_l && !nck) exp_err = 1'b1;
    ext_clk = nck; clk_inh = nih; sel_shift = nsel; ser_in = nser; par_in = npar;
    ck_l = nck; ih_l = nih;
    repeat (4) @(negedge clk);
    chk_all(req);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    exp_q = '0; exp_err = 1'b0;
    chk_all("R6 async clear");
    ext_clk = 1'b1; sel_shift = 1'b0; par_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk_all("R6 clear overrides clock");
    ext_clk = 1'b0; clk_inh = 1'b0; ck_l = 1'b0; ih_l = 1'b0;
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_all("R6 after release");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ld;
    void'($urandom(32'd4711));
    clr_n = 1'b0; sel_shift = 1'b0; ser_in = 1'b0; par_in = '0;
    ext_clk = 1'b0; clk_inh = 1'b0; ck_l = 1'b0; ih_l = 1'b0;
    exp_q = '0; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R6 reset state");
    clr_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: data change without an edge does nothing
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hB4, "R2 no edge yet");
    // R2/R3 load with ser_in high, then same byte with ser_in low
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'hB4, "R2 load");
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R7 clock fall");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hB4, "R3 load ignores ser_in");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R7 clock fall");
    // R9: bits leave msb first
    ld = 8'hB4;
    for (int k = 7; k >= 0; k--) begin
      checks++;
      if (ser_out !== ld[k]) begin
        errors++;
        $display("FAIL R9 bit %0d actual=%b expected=%b", k, ser_out, ld[k]);
      end
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R1 shift");
      step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R7 hold");
    end
    // R4: inhibit high blocks ext_clk pulses (inh rises with clk high: no flag)
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R4 load");
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, "R8 inh rise clk high no flag");
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, "R4 inhibited fall");
    step(1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, "R4 inhibited rise");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hC3, "R4 inhibited fall");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, "R5 stop with inhibit");
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hC3, "R5 inh fall clk high");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'hC3, "R7 clock fall");
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, "R5 restart");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'hC3, "R7 clock fall");
    // R5/R8: inhibit as clock with ext_clk low, flag sets and sticks
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, "R5 inh as clock");
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R8 sticky");
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R8 sticky after shift");
    do_clear();

    for (int i = 0; i < 400; i++) begin
      if (($urandom % 25) == 0) begin
        do_clear();
      end else begin
        step(1'($urandom), 1'(($urandom % 4) == 0), 1'($urandom), 1'($urandom),
             8'($urandom), "R1/R2/R4/R7/R8 random");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule